// File: doc/BRIEF.md
# Embedded Memory Self-Test Engine

This block runs a self-test on a small memory that sits next to it. A test controller loads the settings and raises a start request. The engine then generates every address, every write word and every strobe by itself, so the controller does not need to shift each access in serially. Address order comes from a linear-feedback shift register with programmable taps. An extra final step covers address zero, so each sweep visits every location once.

For RAM, one pass writes the whole memory and then reads the whole memory back. Write data is either a second pseudorandom sequence or an alternating all-ones/all-zeros word. Each data bit has a small cell that holds the value sent out with a read. When the memory answers one cycle later, the cell compares the returned bit with that held value. The per-bit results are masked and merged into a sticky pass/fail flag. For ROM, the engine only reads. The returned words are folded into a parallel signature register, and the final signature is compared with an expected value.

The memory is attached through plain address, data and strobe ports. Reads have a fixed latency of one clock. All settings are sampled on the clock edge that accepts the start request.

Top module: `mbist_engine`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `fail`, `mem_we` and `mem_re` are low and `signature` is zero.
- R2: Address order follows this rule. The next state is `{s[N-2:0], s[N-1] ^ parity(s[N-2:0] & taps[N-2:0])}`; the top bit always feeds back and `taps[N-1]` is ignored. The first address is `addr_seed`, or 1 when the seed is zero. After 2^N-1 register states, one extra step issues address 0. With maximal taps (0xB8 for N=8), each sweep touches every address exactly once.
- R3: A RAM test issues 2^N consecutive write cycles (`mem_we`), then 2^N consecutive read cycles (`mem_re`) in the same address order. The two strobes are never high together.
- R4: In mode 0, word k of a sweep is the data register after k steps. The register starts at `data_seed` and uses the same shift rule as R2 with `data_taps`. The read sweep replays the same words.
- R5: In mode 1, word k is all ones for even k and all zeros for odd k.
- R6: `mem_rdata` is sampled one clock after each read strobe and compared bit by bit with the word sent out with that read. Bits set in `cmp_mask` never cause a failure.
- R7: A RAM mismatch sets `fail`. The flag holds until the next accepted start, which clears it.
- R8: Modes 2 and 3 (mode bit 1 set) test a ROM with reads only. The signature starts at 0. On each returned word it becomes `{sig[W-2:0], parity(sig & psa_taps)} ^ (rdata & ~psa_mask)`. At the end, `fail` is set if the signature differs from `sig_expect`. `signature` then holds still until the next start.
- R9: Counting the clock edge that accepts start as edge 0, `done` is first high after edge 2^(N+1)+1 for RAM and after edge 2^N+1 for ROM. `busy` is high from start until `done`. `done` stays high until the next accepted start.
- R10: While `busy` is high, `start` is ignored. Changes on the mode, seed, tap, mask and expected-signature inputs have no effect on a running test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, accepted only when idle |
| mode | input | 2 | 0 RAM pseudorandom, 1 RAM toggle, 2/3 ROM signature |
| addr_seed | input | ADDR_W | Address register seed |
| addr_taps | input | ADDR_W | Address feedback taps |
| data_seed | input | DATA_W | Data register seed |
| data_taps | input | DATA_W | Data feedback taps |
| cmp_mask | input | DATA_W | 1 excludes a bit from RAM comparison |
| psa_taps | input | DATA_W | Signature feedback taps |
| psa_mask | input | DATA_W | 1 excludes a bit from signature folding |
| sig_expect | input | DATA_W | Known-good ROM signature |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | DATA_W | Memory read data, one clock after `mem_re` |
| busy | output | 1 | Test running |
| done | output | 1 | Test finished |
| fail | output | 1 | Sticky failure result |
| signature | output | DATA_W | Signature register |

## Verification
The bench uses the default parameters, 8 address bits and 8 data bits, so the memory has 256 words. This lets it confirm with tap value 0xB8 that a whole sweep writes each of the 256 locations exactly once, including the extra step for address zero. It also confirms that the zero seed is replaced, and that the latency to `done` is 514 and 258 sampling periods for RAM and ROM. The bench memory model flips one chosen bit at one address to inject faults. Runs with and without the matching mask bit show that the mask excludes the flipped bit from the result.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_WRITE = 2'd1,
        SEQ_READ  = 2'd2,
        SEQ_DRAIN = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        TM_RAM_PRPG   = 2'd0,
        TM_RAM_TOGGLE = 2'd1,
        TM_ROM_SIG    = 2'd2,
        TM_ROM_SIG_B  = 2'd3
    } test_mode_e;

    typedef struct packed {
        logic rom;
        logic toggle;
    } mode_flags_t;

    function automatic mode_flags_t decode_mode(input logic [1:0] m);
        mode_flags_t f;
        f.rom    = m[1];
        f.toggle = (m == TM_RAM_TOGGLE);
        return f;
    endfunction

endpackage

// File: rtl/bist_addr_gen.sv
module bist_addr_gen #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] seed,
    input  logic [ADDR_W-1:0] taps,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] LAST_IDX = '1;

    logic [ADDR_W-1:0] lfsr_q, lfsr_nx, idx_q, seed_nz;
    logic              fb;

    // top bit always feeds back, keeping the register invertible and nonzero
    assign fb      = lfsr_q[ADDR_W-1] ^ (^(lfsr_q[ADDR_W-2:0] & taps[ADDR_W-2:0]));
    assign lfsr_nx = {lfsr_q[ADDR_W-2:0], fb};
    assign seed_nz = (seed == '0) ? ONE : seed;

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q <= ONE;
            idx_q  <= '0;
        end else if (load) begin
            lfsr_q <= seed_nz;
            idx_q  <= '0;
        end else if (step) begin
            lfsr_q <= lfsr_nx;
            idx_q  <= idx_q + ONE;
        end
    end

    assign last = (idx_q == LAST_IDX);
    assign addr = last ? '0 : lfsr_q;

    p_lfsr_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);

    p_zero_only_at_end_r2: assert property (@(posedge clk) disable iff (rst)
        (step && !last) |-> (addr != '0));

endmodule

// File: rtl/bist_data_cells.sv
module bist_data_cells #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic              toggle,
    input  logic [DATA_W-1:0] seed,
    input  logic [DATA_W-1:0] taps,
    input  logic              capture,
    input  logic              cmp_en,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] wdata,
    output logic              miss
);
    logic [DATA_W-1:0] pat_q, pat_nx, pattern, bit_miss;
    logic              tog_q;

    assign pat_nx  = {pat_q[DATA_W-2:0],
                      pat_q[DATA_W-1] ^ (^(pat_q[DATA_W-2:0] & taps[DATA_W-2:0]))};
    assign pattern = toggle ? {DATA_W{~tog_q}} : pat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pat_q <= '0;
            tog_q <= 1'b0;
        end else if (load) begin
            pat_q <= seed;
            tog_q <= 1'b0;
        end else if (step) begin
            pat_q <= pat_nx;
            tog_q <= ~tog_q;
        end
    end

    // one cell per data bit: hold the bit issued with a read, compare on return
    for (genvar i = 0; i < DATA_W; i++) begin : g_cell
        logic held_q;
        always_ff @(posedge clk) begin
            if (rst)          held_q <= 1'b0;
            else if (capture) held_q <= pattern[i];
        end
        assign bit_miss[i] = cmp_en & ~mask[i] & (rdata[i] ^ held_q);
    end

    assign wdata = pattern;
    assign miss  = |bit_miss;

    p_toggle_alternates_r5: assert property (@(posedge clk) disable iff (rst)
        (toggle && step && !load) |=> (wdata == ~$past(wdata)));

endmodule

// File: rtl/bist_psa.sv
module bist_psa #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              en,
    input  logic [DATA_W-1:0] taps,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] sig,
    output logic [DATA_W-1:0] sig_nx
);
    logic [DATA_W-1:0] sig_q;

    assign sig_nx = {sig_q[DATA_W-2:0], ^(sig_q & taps)} ^ (din & ~mask);

    always_ff @(posedge clk) begin
        if (rst || clear) sig_q <= '0;
        else if (en)      sig_q <= sig_nx;
    end

    assign sig = sig_q;

    p_psa_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!en && !clear) |=> $stable(sig_q));

endmodule

// File: rtl/mbist_engine.sv
module mbist_engine
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] addr_seed,
    input  logic [ADDR_W-1:0] addr_taps,
    input  logic [DATA_W-1:0] data_seed,
    input  logic [DATA_W-1:0] data_taps,
    input  logic [DATA_W-1:0] cmp_mask,
    input  logic [DATA_W-1:0] psa_taps,
    input  logic [DATA_W-1:0] psa_mask,
    input  logic [DATA_W-1:0] sig_expect,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [DATA_W-1:0] signature
);
    seq_state_e        state_q, state_d;
    mode_flags_t       cfg_flags_q, req_flags;
    logic [ADDR_W-1:0] cfg_aseed_q, cfg_ataps_q, aseed_mux;
    logic [DATA_W-1:0] cfg_dseed_q, cfg_dtaps_q, cfg_cmask_q;
    logic [DATA_W-1:0] cfg_ptaps_q, cfg_pmask_q, cfg_sexp_q, dseed_mux;
    logic              start_acc, gen_load, gen_step, addr_last;
    logic              rd_valid_q, fail_q, done_q, cell_miss;
    logic [DATA_W-1:0] sig_nx;

    assign req_flags = decode_mode(mode);
    assign start_acc = start && (state_q == SEQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_flags_q <= '0;
            cfg_aseed_q <= '0;
            cfg_ataps_q <= '0;
            cfg_dseed_q <= '0;
            cfg_dtaps_q <= '0;
            cfg_cmask_q <= '0;
            cfg_ptaps_q <= '0;
            cfg_pmask_q <= '0;
            cfg_sexp_q  <= '0;
        end else if (start_acc) begin
            cfg_flags_q <= req_flags;
            cfg_aseed_q <= addr_seed;
            cfg_ataps_q <= addr_taps;
            cfg_dseed_q <= data_seed;
            cfg_dtaps_q <= data_taps;
            cfg_cmask_q <= cmp_mask;
            cfg_ptaps_q <= psa_taps;
            cfg_pmask_q <= psa_mask;
            cfg_sexp_q  <= sig_expect;
        end
    end

    // restart both generators at start and again when the read sweep begins
    assign gen_load  = start_acc || (state_q == SEQ_WRITE && addr_last);
    assign gen_step  = (state_q == SEQ_WRITE) || (state_q == SEQ_READ);
    assign aseed_mux = start_acc ? addr_seed : cfg_aseed_q;
    assign dseed_mux = start_acc ? data_seed : cfg_dseed_q;

    bist_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk  (clk),
        .rst  (rst),
        .load (gen_load),
        .step (gen_step),
        .seed (aseed_mux),
        .taps (cfg_ataps_q),
        .addr (mem_addr),
        .last (addr_last)
    );

    bist_data_cells #(.DATA_W(DATA_W)) u_cells (
        .clk     (clk),
        .rst     (rst),
        .load    (gen_load),
        .step    (gen_step),
        .toggle  (cfg_flags_q.toggle),
        .seed    (dseed_mux),
        .taps    (cfg_dtaps_q),
        .capture (mem_re),
        .cmp_en  (rd_valid_q && !cfg_flags_q.rom),
        .rdata   (mem_rdata),
        .mask    (cfg_cmask_q),
        .wdata   (mem_wdata),
        .miss    (cell_miss)
    );

    bist_psa #(.DATA_W(DATA_W)) u_psa (
        .clk    (clk),
        .rst    (rst),
        .clear  (start_acc),
        .en     (rd_valid_q && cfg_flags_q.rom),
        .taps   (cfg_ptaps_q),
        .mask   (cfg_pmask_q),
        .din    (mem_rdata),
        .sig    (signature),
        .sig_nx (sig_nx)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (start_acc) state_d = req_flags.rom ? SEQ_READ : SEQ_WRITE;
            SEQ_WRITE: if (addr_last) state_d = SEQ_READ;
            SEQ_READ:  if (addr_last) state_d = SEQ_DRAIN;
            SEQ_DRAIN: state_d = SEQ_IDLE;
            default:   state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SEQ_IDLE;
            rd_valid_q <= 1'b0;
            fail_q     <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            state_q    <= state_d;
            rd_valid_q <= (state_q == SEQ_READ);
            if (start_acc) begin
                fail_q <= 1'b0;
                done_q <= 1'b0;
            end else begin
                if (!cfg_flags_q.rom && rd_valid_q && cell_miss)
                    fail_q <= 1'b1;
                if (cfg_flags_q.rom && state_q == SEQ_DRAIN && sig_nx != cfg_sexp_q)
                    fail_q <= 1'b1;
                if (state_q == SEQ_DRAIN)
                    done_q <= 1'b1;
            end
        end
    end

    assign mem_we = (state_q == SEQ_WRITE);
    assign mem_re = (state_q == SEQ_READ);
    assign busy   = (state_q != SEQ_IDLE);
    assign done   = done_q;
    assign fail   = fail_q;

    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    p_write_then_read_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we) |-> mem_re);

    p_fail_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> fail);

    p_rom_no_write_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && cfg_flags_q.rom) |-> !mem_we);

    p_sig_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(signature));

    p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_done_from_drain_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(state_q == SEQ_DRAIN));

    p_keep_running_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && state_q != SEQ_DRAIN) |=> busy);

    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(cfg_flags_q) && $stable(cfg_cmask_q) && $stable(cfg_sexp_q)));

endmodule

// File: tb/tb_mbist_engine.sv
module tb_mbist_engine;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 8;
    localparam int DW         = 8;
    localparam int DEPTH      = 1 << AW;
    localparam int RAM_LAT    = 2 * DEPTH + 2;
    localparam int ROM_LAT    = DEPTH + 2;
    localparam int WATCHDOG   = 100000;

    logic          clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [AW-1:0] addr_seed = '0, addr_taps = '0, mem_addr;
    logic [DW-1:0] data_seed = '0, data_taps = '0, cmp_mask = '0;
    logic [DW-1:0] psa_taps = '0, psa_mask = '0, sig_expect = '0;
    logic [DW-1:0] mem_wdata, mem_rdata = '0, signature;
    logic          mem_we, mem_re, busy, done, fail;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mbist_engine #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .addr_seed(addr_seed), .addr_taps(addr_taps),
        .data_seed(data_seed), .data_taps(data_taps),
        .cmp_mask(cmp_mask), .psa_taps(psa_taps), .psa_mask(psa_mask),
        .sig_expect(sig_expect), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .fail(fail), .signature(signature)
    );

    int errors = 0, checks = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory model with a single bit-flip fault on read
    logic [DW-1:0] mem [DEPTH];
    bit            flt_en = 1'b0;
    logic [AW-1:0] flt_addr = '0;
    int            flt_bit = 0;

    function automatic logic [DW-1:0] rd_model(input logic [AW-1:0] a);
        logic [DW-1:0] v;
        v = mem[a];
        if (flt_en && a == flt_addr) v[flt_bit] = ~v[flt_bit];
        return v;
    endfunction

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= rd_model(mem_addr);
    end

    function automatic logic [7:0] shift_nx(input logic [7:0] c, input logic [7:0] t);
        return {c[6:0], c[7] ^ (^(c[6:0] & t[6:0]))};
    endfunction

    // scoreboard queues
    typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; } wr_item_t;
    typedef struct packed { logic f; logic [DW-1:0] s; int lat; } res_item_t;
    wr_item_t      wr_q [$];
    logic [AW-1:0] rd_q [$];
    res_item_t     res_q [$];
    string         tag_data = "R4", tag_res = "R6";
    int            wr_hits [DEPTH];

    wr_item_t      mon_w;
    logic [AW-1:0] mon_a;
    res_item_t     mon_r;
    int            lat_cnt = 0;
    bit            armed = 1'b0, done_d = 1'b0;

    // monitor: pops expected items as the design produces them
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) begin
                if (wr_q.size() == 0) check(1'b0, "R3", "unexpected write", 32'(mem_addr), 0);
                else begin
                    mon_w = wr_q.pop_front();
                    check(mem_addr == mon_w.a, "R2", "write address", 32'(mem_addr), 32'(mon_w.a));
                    check(mem_wdata == mon_w.d, tag_data, "write data", 32'(mem_wdata), 32'(mon_w.d));
                    wr_hits[mem_addr]++;
                end
            end
            if (mem_re) begin
                if (rd_q.size() == 0) check(1'b0, "R3", "unexpected read", 32'(mem_addr), 0);
                else begin
                    mon_a = rd_q.pop_front();
                    check(mem_addr == mon_a, "R3", "read address", 32'(mem_addr), 32'(mon_a));
                end
            end
            if (start && !busy) begin
                lat_cnt = 0;
                armed   = 1'b1;
            end else if (armed) lat_cnt++;
            if (done && !done_d && armed) begin
                armed = 1'b0;
                if (res_q.size() == 0) check(1'b0, "R9", "unexpected done", 1, 0);
                else begin
                    mon_r = res_q.pop_front();
                    check(fail == mon_r.f, tag_res, "pass/fail result", 32'(fail), 32'(mon_r.f));
                    check(signature == mon_r.s, "R8", "signature", 32'(signature), 32'(mon_r.s));
                    check(lat_cnt == mon_r.lat, "R9", "cycles to done", 32'(lat_cnt), 32'(mon_r.lat));
                end
            end
            done_d = done;
        end
    end

    // driver: computes expectations from the requirements, then runs the test
    task automatic run_test(input logic [1:0] m, input logic [AW-1:0] as, at,
                            input logic [DW-1:0] ds, dt, cm, pt, pm,
                            input bit bad_sig, input bit poke, input bit want_cov,
                            input string tdata, input string tres);
        logic [AW-1:0] a;
        logic [DW-1:0] d, v, sig, sexp;
        logic [AW-1:0] addrs [DEPTH];
        logic [DW-1:0] pats  [DEPTH];
        logic [DW-1:0] img   [DEPTH];
        res_item_t     r;
        wr_item_t      w;
        bit            rom, tog, ef;
        int            bad;
        rom = m[1];
        tog = (m == 2'd1);
        a   = (as == '0) ? AW'(1) : as;
        d   = ds;
        for (int k = 0; k < DEPTH; k++) begin
            addrs[k] = (k == DEPTH - 1) ? '0 : a;
            pats[k]  = tog ? ((k % 2 == 0) ? '1 : '0) : d;
            a = shift_nx(a, at);
            d = shift_nx(d, dt);
        end
        for (int i = 0; i < DEPTH; i++) img[i] = mem[i];
        if (!rom) begin
            for (int k = 0; k < DEPTH; k++) begin
                img[addrs[k]] = pats[k];
                w.a = addrs[k];
                w.d = pats[k];
                wr_q.push_back(w);
            end
        end
        ef  = 1'b0;
        sig = '0;
        for (int k = 0; k < DEPTH; k++) begin
            rd_q.push_back(addrs[k]);
            v = img[addrs[k]];
            if (flt_en && addrs[k] == flt_addr) v[flt_bit] = ~v[flt_bit];
            if (rom) sig = {sig[DW-2:0], ^(sig & pt)} ^ (v & ~pm);
            else if (((v ^ pats[k]) & ~cm) != '0) ef = 1'b1;
        end
        sexp = bad_sig ? (sig ^ 8'h01) : sig;
        if (rom) ef = (sig != sexp);
        r.f   = ef;
        r.s   = rom ? sig : '0;
        r.lat = rom ? ROM_LAT : RAM_LAT;
        res_q.push_back(r);
        tag_data = tdata;
        tag_res  = tres;
        for (int i = 0; i < DEPTH; i++) wr_hits[i] = 0;

        @(posedge clk); #1;
        mode = m; addr_seed = as; addr_taps = at; data_seed = ds; data_taps = dt;
        cmp_mask = cm; psa_taps = pt; psa_mask = pm; sig_expect = sexp;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (poke) begin
            repeat (100) @(posedge clk);
            #1;
            mode = 2'd2; addr_seed = ~as; data_seed = ~ds; cmp_mask = '1;
            sig_expect = ~sexp; psa_mask = '1;
            start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
            @(negedge clk);
            check(busy == 1'b1, "R10", "busy after start while running", 32'(busy), 1);
        end
        @(negedge clk);
        while (!done) @(negedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R9", "busy after done", 32'(busy), 0);
        check(wr_q.size() == 0, "R3", "writes left over", 32'(wr_q.size()), 0);
        check(rd_q.size() == 0, "R3", "reads left over", 32'(rd_q.size()), 0);
        if (want_cov) begin
            bad = 0;
            for (int i = 0; i < DEPTH; i++) if (wr_hits[i] != 1) bad++;
            check(bad == 0, "R2", "addresses not written exactly once", 32'(bad), 0);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R9 watchdog: actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R1", "busy after reset", 32'(busy), 0);
        check(done == 1'b0, "R1", "done after reset", 32'(done), 0);
        check(fail == 1'b0, "R1", "fail after reset", 32'(fail), 0);
        check(mem_we == 1'b0 && mem_re == 1'b0, "R1", "strobes after reset",
              32'({mem_we, mem_re}), 0);
        check(signature == '0, "R1", "signature after reset", 32'(signature), 0);

        // R4: pseudorandom data, clean memory, full coverage with maximal taps
        run_test(2'd0, 8'h01, 8'hB8, 8'h5C, 8'h8E, 8'h00, 8'h00, 8'h00,
                 1'b0, 1'b0, 1'b1, "R4", "R6");
        check(fail == 1'b0, "R6", "clean RAM pass", 32'(fail), 0);

        // R6/R7: flipped bit detected and held
        flt_en = 1'b1; flt_addr = 8'h37; flt_bit = 2;
        run_test(2'd0, 8'hA3, 8'hB8, 8'h11, 8'h2D, 8'h00, 8'h00, 8'h00,
                 1'b0, 1'b0, 1'b1, "R4", "R6");
        check(fail == 1'b1, "R6", "flipped bit detected", 32'(fail), 1);
        repeat (20) @(negedge clk);
        check(fail == 1'b1, "R7", "fail held while idle", 32'(fail), 1);
        check(done == 1'b1, "R9", "done held while idle", 32'(done), 1);

        // R6 mask, R7 cleared by the next start
        run_test(2'd0, 8'hA3, 8'hB8, 8'h11, 8'h2D, 8'h04, 8'h00, 8'h00,
                 1'b0, 1'b0, 1'b1, "R4", "R7");
        check(fail == 1'b0, "R7", "masked bit passes, flag cleared", 32'(fail), 0);

        // R5 toggle data, zero seed (R2), fault at the extra zero address
        flt_addr = 8'h00; flt_bit = 7;
        run_test(2'd1, 8'h00, 8'hB8, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
                 1'b0, 1'b0, 1'b1, "R5", "R6");
        check(fail == 1'b1, "R2", "zero address read and checked", 32'(fail), 1);

        // ROM content
        flt_en = 1'b0;
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'(i * 13) ^ 8'hA5;

        run_test(2'd2, 8'h5A, 8'hB8, 8'h00, 8'h00, 8'h00, 8'hB4, 8'h00,
                 1'b0, 1'b0, 1'b0, "R8", "R8");
        check(fail == 1'b0, "R8", "good ROM signature passes", 32'(fail), 0);

        run_test(2'd3, 8'h33, 8'hE1, 8'h00, 8'h00, 8'h00, 8'h63, 8'h00,
                 1'b1, 1'b0, 1'b0, "R8", "R8");
        check(fail == 1'b1, "R8", "wrong expected signature fails", 32'(fail), 1);

        flt_en = 1'b1; flt_addr = 8'h10; flt_bit = 0;
        run_test(2'd2, 8'h5A, 8'hB8, 8'h00, 8'h00, 8'h00, 8'hB4, 8'h01,
                 1'b0, 1'b0, 1'b0, "R8", "R8");
        check(fail == 1'b0, "R8", "masked folded bit passes", 32'(fail), 0);

        // R10: start and config changes while busy are ignored
        flt_en = 1'b0;
        run_test(2'd0, 8'h7E, 8'hB8, 8'h42, 8'h9C, 8'h00, 8'h00, 8'h00,
                 1'b0, 1'b1, 1'b1, "R10", "R10");
        check(fail == 1'b0, "R10", "run unaffected by late start", 32'(fail), 0);

        summary();
        $finish;
    end
endmodule